// File: doc/BRIEF.md
# DMA Channel FIFO Readiness Evaluator

This block decides, every cycle and without any state, whether a DMA channel's FIFO can accept one more source-side write and whether it holds enough data for one destination-side read. It reads the FIFO fill level in bytes and a handful of channel settings. It drives two ready flags that the source and destination sequencers of the channel use before they ask for the bus.

There are two readiness rules. The per-transfer rule asks only for room, or for data, of one transfer at the programmed width. The half-threshold rule is chosen with `thresh_mode`. It applies to burst requests and to memory peripherals, and it holds the source back until the FIFO is below half depth. It holds the destination back until the FIFO is at least half full. Several conditions make a side fall back to the per-transfer rule: the end of a burst or block is near, the channel is in flush mode, or, for the destination only, the channel is suspended. In flush mode the destination also measures its data against the source width, so a partial tail can drain.

Top module: `dma_fifo_ready`

## Requirements
- R1: With the per-transfer rule in force, `src_ready` is 1 exactly when `DEPTH - fill_bytes` is at least the source transfer size in bytes.
- R2: With the per-transfer rule in force and flush inactive, `dst_ready` is 1 exactly when `fill_bytes` is at least the destination transfer size in bytes.
- R3: While `flush_en` is 1, `dst_ready` is 1 exactly when `fill_bytes` is at least the source transfer size. The destination width then has no effect.
- R4: When `thresh_mode`=1, (`burst_req`=1 or `mem_periph`=1), `flush_en`=0 and `src_left` >= DEPTH/2, `src_ready` is 1 exactly when `fill_bytes` < DEPTH/2.
- R5: When `thresh_mode`=1, (`burst_req`=1 or `mem_periph`=1), `flush_en`=0, `suspended`=0 and `dst_left` >= DEPTH/2, `dst_ready` is 1 exactly when `fill_bytes` >= DEPTH/2.
- R6: When `src_left` < DEPTH/2, the source uses the per-transfer rule of R1 whatever `thresh_mode` is.
- R7: When `dst_left` < DEPTH/2, the destination uses the per-transfer rule of R2/R3 whatever `thresh_mode` is.
- R8: While `suspended` is 1, the destination uses the per-transfer rule whatever `thresh_mode` is. The source is unaffected.
- R9: While `flush_en` is 1, neither side uses the half-threshold rule.
- R10: With `burst_req`=0 and `mem_periph`=0, `thresh_mode` has no effect on either output.
- R11: The width codes give the transfer size in bytes as follows: 0 gives 1, 1 gives 2, 2 gives 4, and the unused code 3 is treated as 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fill_bytes | input | $clog2(DEPTH+1) | Bytes currently held in the channel FIFO |
| src_width | input | 2 | Source transfer width code (log2 of bytes) |
| dst_width | input | 2 | Destination transfer width code (log2 of bytes) |
| thresh_mode | input | 1 | 1 selects the half-depth criterion for bursts and memory |
| burst_req | input | 1 | 1 when the pending request is a burst, 0 for a single |
| mem_periph | input | 1 | 1 when the peripheral on this side is memory |
| flush_en | input | 1 | Channel is in flush mode |
| suspended | input | 1 | Channel is suspended |
| src_left | input | LEFT_W | Source items left in the current burst or block |
| dst_left | input | LEFT_W | Destination items left in the current burst or block |
| src_ready | output | 1 | FIFO can accept one source transfer |
| dst_ready | output | 1 | FIFO can supply one destination transfer |

## Verification
The assertions assume that `fill_bytes` never exceeds DEPTH. They are skipped while any input is unknown, because the block is combinational and has no reset. The bench keeps the fill level in the range 0 to DEPTH. It sweeps every width code, including the unused one, and every combination of the five flags. For the items-left counts it uses values on both sides of DEPTH/2, so that each fallback condition is reached from both sides of its boundary.

// File: rtl/dma_fifo_ready.sv
module dma_fifo_ready #(
  parameter int DEPTH  = 16,
  parameter int LEFT_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int HALF  = DEPTH / 2
) (
  input  logic [CNT_W-1:0]  fill_bytes,
  input  logic [1:0]        src_width,
  input  logic [1:0]        dst_width,
  input  logic              thresh_mode,
  input  logic              burst_req,
  input  logic              mem_periph,
  input  logic              flush_en,
  input  logic              suspended,
  input  logic [LEFT_W-1:0] src_left,
  input  logic [LEFT_W-1:0] dst_left,
  output logic              src_ready,
  output logic              dst_ready
);

  function automatic logic [CNT_W:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return (CNT_W+1)'(1);
      2'd1:    return (CNT_W+1)'(2);
      default: return (CNT_W+1)'(4);
    endcase
  endfunction

  logic [CNT_W:0] fill_x, room_x, src_sz, dst_sz, half_x;
  logic           thr_ok, src_thr, dst_thr;

  assign fill_x = {1'b0, fill_bytes};
  assign room_x = (CNT_W+1)'(DEPTH) - fill_x;
  assign half_x = (CNT_W+1)'(HALF);
  assign src_sz = width_bytes(src_width);
  assign dst_sz = flush_en ? width_bytes(src_width) : width_bytes(dst_width);

  assign thr_ok  = thresh_mode && (burst_req || mem_periph) && !flush_en;
  assign src_thr = thr_ok && (src_left >= LEFT_W'(HALF));
  assign dst_thr = thr_ok && !suspended && (dst_left >= LEFT_W'(HALF));

  assign src_ready = src_thr ? (fill_x < half_x)  : (room_x >= src_sz);
  assign dst_ready = dst_thr ? (fill_x >= half_x) : (fill_x >= dst_sz);

endmodule

module dma_fifo_ready_chk #(
  parameter int DEPTH  = 16,
  parameter int LEFT_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic [CNT_W-1:0]  fill_bytes,
  input logic [1:0]        src_width,
  input logic [1:0]        dst_width,
  input logic              thresh_mode,
  input logic              burst_req,
  input logic              mem_periph,
  input logic              flush_en,
  input logic              suspended,
  input logic [LEFT_W-1:0] src_left,
  input logic [LEFT_W-1:0] dst_left,
  input logic              src_ready,
  input logic              dst_ready
);
  int sb, fb;
  logic known;
  always_comb begin
    known = !$isunknown({fill_bytes, src_width, dst_width, thresh_mode, burst_req,
                         mem_periph, flush_en, suspended, src_left, dst_left});
    sb = (src_width == 2'd3) ? 4 : (1 << src_width);
    fb = int'(fill_bytes);
    if (known && fb <= DEPTH) begin
      if (!thresh_mode)
        AST_SRC_PER_XFER: assert (src_ready == ((DEPTH - fb) >= sb)); // R1
      if (flush_en)
        AST_FLUSH_SRC_WIDTH: assert (dst_ready == (fb >= sb)); // R3
      if (thresh_mode && burst_req && !flush_en && int'(src_left) >= DEPTH/2 && fb >= DEPTH/2)
        AST_SRC_HELD_AT_HALF: assert (!src_ready); // R4
      if (thresh_mode && mem_periph && !flush_en && !suspended && int'(dst_left) >= DEPTH/2 && fb < DEPTH/2)
        AST_DST_WAITS_HALF: assert (!dst_ready); // R5
      if (suspended && !flush_en && fb >= 4)
        AST_SUSPEND_DRAINS: assert (dst_ready); // R8
    end
  end
endmodule

bind dma_fifo_ready dma_fifo_ready_chk #(.DEPTH(DEPTH), .LEFT_W(LEFT_W)) u_chk (.*);

// File: tb/dma_fifo_ready_test.sv
module dma_fifo_ready_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LEFT_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [CNT_W-1:0]  fill_bytes = '0;
  logic [1:0]        src_width = '0, dst_width = '0;
  logic              thresh_mode = 0, burst_req = 0, mem_periph = 0, flush_en = 0, suspended = 0;
  logic [LEFT_W-1:0] src_left = '0, dst_left = '0;
  logic              src_ready, dst_ready;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  dma_fifo_ready #(.DEPTH(DEPTH), .LEFT_W(LEFT_W)) uut (.*);

  function automatic int bytes_of(input int code);
    return (code >= 2) ? 4 : (code == 1 ? 2 : 1);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s fill=%0d sw=%0d dw=%0d m=%0b b=%0b mem=%0b fl=%0b su=%0b sl=%0d dl=%0d act=%0b exp=%0b",
               req, fill_bytes, src_width, dst_width, thresh_mode, burst_req, mem_periph,
               flush_en, suspended, src_left, dst_left, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int lefts[4] = '{0, HALF-1, HALF, DEPTH};
    #3;
    check("R2 idle empty dst", dst_ready, 1'b0);
    check("R1 idle empty src", src_ready, 1'b1);
    for (int f = 0; f <= DEPTH; f++)
      for (int sw = 0; sw < 4; sw++)
        for (int dw = 0; dw < 4; dw++)
          for (int fl = 0; fl < 32; fl++)
            for (int li = 0; li < 16; li++) begin
              int sb, db, ds;
              bit big, srcthr, dstthr;
              string st, dt;
              fill_bytes = CNT_W'(f);
              src_width = 2'(sw); dst_width = 2'(dw);
              {thresh_mode, burst_req, mem_periph, flush_en, suspended} = 5'(fl);
              src_left = LEFT_W'(lefts[li % 4]);
              dst_left = LEFT_W'(lefts[li / 4]);
              #1;
              sb = bytes_of(sw); db = bytes_of(dw);
              big = thresh_mode && (burst_req || mem_periph) && !flush_en;
              srcthr = big && lefts[li % 4] >= HALF;
              dstthr = big && !suspended && lefts[li / 4] >= HALF;
              ds = flush_en ? sb : db;
              if (srcthr) st = "R4";
              else if (lefts[li % 4] < HALF) st = "R6";
              else if (!(burst_req || mem_periph)) st = "R10";
              else if (flush_en) st = "R9";
              else st = (sw == 3) ? "R11" : "R1";
              if (dstthr) dt = "R5";
              else if (flush_en) dt = "R3";
              else if (suspended) dt = "R8";
              else if (lefts[li / 4] < HALF) dt = "R7";
              else dt = (dw == 3) ? "R11" : "R2";
              check(st, src_ready, srcthr ? (f < HALF) : ((DEPTH - f) >= sb));
              check(dt, dst_ready, dstthr ? (f >= HALF) : (f >= ds));
              #1;
            end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule